// File: doc/BRIEF.md
# GPIO Bank Register Controller

This block exposes a bank of general-purpose pins to software through a flat 32-bit register bus. The bus carries a byte address, a write strobe, write data, and read data that follows the address in the same cycle. Two register layouts share the map. Bitmap registers pack 32 pins into each word. Each pin also has two configuration words of its own, spaced 8 bytes apart.

Each pin can be set to one of two functions: its native function or plain GPIO. It also has a direction, a driven level, a weak-pull code and a sense-disable switch. The block drives a per-pin output enable and output value, and it brings each pad input through a synchronizer. The synchronized, gated input goes to a separate interrupt-detection block. That block also receives the trigger-mode bits, the per-pin interrupt enables and a global routing word, all of which are stored here.

Top module: `gpio_bank_regs`

## Requirements
- R1: After reset, every pin's first configuration word reads 0x00000005 (GPIO function at bit 0, input direction at bit 2) and its second word reads 0x00000004 (sensing disabled at bit 2). Every ownership bitmap bit reads 1, and the enable bitmap and routing word read 0. No pad_oe bit is set.
- R2: Pin n has its first configuration word at byte 0x100 + 8n and its second at 0x104 + 8n. Bitmap word k of the ownership map is at 0x00 + 4k and of the enable map at 0x90 + 4k. Pin n occupies bit n mod 32 of word n/32. The routing word is at 0x7C.
- R3: In the first configuration word these bits are read/write: bit 31 (output level), bit 4 (trigger mode), bit 3 (trigger invert), bit 2 (direction, 1 = input) and bit 0 (function, 1 = GPIO). Bit 30 is the read-only input level. Every other bit reads 0, and writes to bit 30 and the other bits are ignored.
- R4: In the second configuration word, bit 2 is sense-disable and bits 1:0 are the weak-pull code, which drives pad_pull[2n+1:2n]. Every other bit reads 0.
- R5: pad_oe[n] is 1 exactly when the function bit is 1 and the direction bit is 0. pad_out[n] equals the output-level bit. Neither changes in a cycle with no write.
- R6: The pad input passes through two flops. A change on pad_in[n] appears on sense_val[n] and in bit 30 after the second rising clock edge.
- R7: While sense-disable is 1, bit 30 and sense_val[n] read 0 whatever the pad level.
- R8: Bitmap bits above the last pin read 0 and ignore writes.
- R9: Addresses outside the mapped registers read 0, and writes to them change no register. This includes the interrupt-status window at 0x80 to 0x8C.
- R10: trig_mode, trig_inv, irq_en and irq_route follow their register bits and change only on a write.
- R11: Writes take effect at the rising clock edge. Reads are combinational, and address bits 1:0 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr |
| pad_in | input | NUM_PINS | Raw pad inputs |
| pad_oe | output | NUM_PINS | Per-pin output enable |
| pad_out | output | NUM_PINS | Per-pin driven level |
| pad_pull | output | 2*NUM_PINS | Weak-pull code, two bits per pin |
| sense_val | output | NUM_PINS | Synchronized, gated input to the interrupt detector |
| trig_mode | output | NUM_PINS | Per-pin trigger mode bit |
| trig_inv | output | NUM_PINS | Per-pin trigger invert bit |
| irq_en | output | NUM_PINS | Per-pin interrupt enable bitmap |
| irq_route | output | DATA_W | Global interrupt routing word |

## Verification
The map is tried with all-ones writes to configuration and bitmap words. These show which bits are stored and which are masked, including the tail bits of the last bitmap word. Writes to holes and to the status window show that no register aliases there. Direction and function are set in their four combinations to separate the output-enable rule from the output-level path. A pad held high while sensing is off, then enabled, then dropped tells the sense gate apart from the two-edge synchronizer delay.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
   // byte offsets of the register regions
   localparam int OWN_OFS   = 32'h000;
   localparam int ROUTE_OFS = 32'h07C;
   localparam int EN_OFS    = 32'h090;
   localparam int CFG_OFS   = 32'h100;

   // first configuration word fields
   localparam int A_OUT   = 31;
   localparam int A_IN    = 30;
   localparam int A_TMODE = 4;
   localparam int A_TINV  = 3;
   localparam int A_DIR   = 2;
   localparam int A_FUNC  = 0;

   // second configuration word fields
   localparam int B_SOFF  = 2;
   localparam int B_PULL  = 0;
   localparam int PULL_W  = 2;

   typedef struct packed {
      logic              out_lvl;
      logic              tmode;
      logic              tinv;
      logic              dir_in;
      logic              func_gpio;
      logic              sense_off;
      logic [PULL_W-1:0] pull;
   } pin_cfg_t;

   localparam pin_cfg_t PIN_CFG_RST = '{out_lvl: 1'b0, tmode: 1'b0, tinv: 1'b0,
                                        dir_in: 1'b1, func_gpio: 1'b1,
                                        sense_off: 1'b1, pull: '0};
endpackage

// File: rtl/gpio_pin_cfg.sv
module gpio_pin_cfg
   import gpio_bank_pkg::*;
#(
   parameter int DATA_W      = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_a,
   input  logic              wr_b,
   input  logic [DATA_W-1:0] wdata,
   input  logic              pad_in,
   output logic [DATA_W-1:0] rd_a,
   output logic [DATA_W-1:0] rd_b,
   output logic              pad_oe,
   output logic              pad_out,
   output logic              sense,
   output logic              tmode,
   output logic              tinv,
   output logic [PULL_W-1:0] pull
);
   if (DATA_W <= A_OUT) begin : g_bad_width
      $error("gpio_pin_cfg: DATA_W too narrow for the field layout");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("gpio_pin_cfg: at least two synchronizer stages needed");
   end

   pin_cfg_t               cfg_q;
   logic [SYNC_STAGES-1:0] sync_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_q <= PIN_CFG_RST;
      end else begin
         if (wr_a) begin
            cfg_q.out_lvl   <= wdata[A_OUT];
            cfg_q.tmode     <= wdata[A_TMODE];
            cfg_q.tinv      <= wdata[A_TINV];
            cfg_q.dir_in    <= wdata[A_DIR];
            cfg_q.func_gpio <= wdata[A_FUNC];
         end
         if (wr_b) begin
            cfg_q.sense_off <= wdata[B_SOFF];
            cfg_q.pull      <= wdata[B_PULL +: PULL_W];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) sync_q <= '0;
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], pad_in};
   end

   assign sense   = sync_q[SYNC_STAGES-1] & ~cfg_q.sense_off;
   assign pad_oe  = cfg_q.func_gpio & ~cfg_q.dir_in;
   assign pad_out = cfg_q.out_lvl;
   assign tmode   = cfg_q.tmode;
   assign tinv    = cfg_q.tinv;
   assign pull    = cfg_q.pull;

   always_comb begin
      rd_a          = '0;
      rd_a[A_OUT]   = cfg_q.out_lvl;
      rd_a[A_IN]    = sense;
      rd_a[A_TMODE] = cfg_q.tmode;
      rd_a[A_TINV]  = cfg_q.tinv;
      rd_a[A_DIR]   = cfg_q.dir_in;
      rd_a[A_FUNC]  = cfg_q.func_gpio;
      rd_b                    = '0;
      rd_b[B_SOFF]            = cfg_q.sense_off;
      rd_b[B_PULL +: PULL_W]  = cfg_q.pull;
   end
endmodule

// File: rtl/gpio_bitmap_bank.sv
module gpio_bitmap_bank #(
   parameter int NUM_BITS   = 94,
   parameter int DATA_W     = 32,
   parameter bit RESET_ONES = 1'b0,
   localparam int NWORDS    = (NUM_BITS + DATA_W - 1) / DATA_W,
   localparam int IDX_W     = (NWORDS > 1) ? $clog2(NWORDS) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                hit,
   input  logic                we,
   input  logic [IDX_W-1:0]    idx,
   input  logic [DATA_W-1:0]   wdata,
   output logic [DATA_W-1:0]   rd_word,
   output logic [NUM_BITS-1:0] bits
);
   localparam int TOT = NWORDS * DATA_W;

   function automatic logic [TOT-1:0] valid_mask();
      logic [TOT-1:0] m;
      m = '0;
      for (int i = 0; i < NUM_BITS; i++) m[i] = 1'b1;
      return m;
   endfunction

   localparam logic [TOT-1:0] VALID = valid_mask();

   logic [TOT-1:0] store_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         store_q <= RESET_ONES ? VALID : '0;
      end else if (hit && we) begin
         for (int w = 0; w < NWORDS; w++) begin
            if (idx == IDX_W'(w))
               store_q[w*DATA_W +: DATA_W] <= wdata & VALID[w*DATA_W +: DATA_W];
         end
      end
   end

   always_comb begin
      rd_word = '0;
      for (int w = 0; w < NWORDS; w++) begin
         if (idx == IDX_W'(w)) rd_word = store_q[w*DATA_W +: DATA_W];
      end
   end

   assign bits = store_q[NUM_BITS-1:0];
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
   import gpio_bank_pkg::*;
#(
   parameter int NUM_PINS = 94,
   parameter int DATA_W   = 32,
   parameter int ADDR_W   = 12
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [ADDR_W-1:0]     bus_addr,
   input  logic                  bus_we,
   input  logic [DATA_W-1:0]     bus_wdata,
   output logic [DATA_W-1:0]     bus_rdata,
   input  logic [NUM_PINS-1:0]   pad_in,
   output logic [NUM_PINS-1:0]   pad_oe,
   output logic [NUM_PINS-1:0]   pad_out,
   output logic [2*NUM_PINS-1:0] pad_pull,
   output logic [NUM_PINS-1:0]   sense_val,
   output logic [NUM_PINS-1:0]   trig_mode,
   output logic [NUM_PINS-1:0]   trig_inv,
   output logic [NUM_PINS-1:0]   irq_en,
   output logic [DATA_W-1:0]     irq_route
);
   localparam int NWORDS    = (NUM_PINS + DATA_W - 1) / DATA_W;
   localparam int IDX_W     = (NWORDS > 1) ? $clog2(NWORDS) : 1;
   localparam int PIN_IDX_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;
   localparam int MAP_END   = CFG_OFS + 8 * NUM_PINS;

   if (DATA_W != 32) begin : g_bad_data
      $error("gpio_bank_regs: the register layout needs 32-bit words");
   end
   if (OWN_OFS + 4 * NWORDS > ROUTE_OFS || EN_OFS + 4 * NWORDS > CFG_OFS) begin : g_bad_map
      $error("gpio_bank_regs: too many pins for the bitmap windows");
   end
   if (MAP_END > (1 << ADDR_W)) begin : g_bad_addr
      $error("gpio_bank_regs: ADDR_W too small for the configuration region");
   end

   // address decode
   int                   a_int;
   logic                 own_hit, en_hit, route_hit, cfg_hit, cfg_second;
   logic [IDX_W-1:0]     own_idx, en_idx;
   logic [PIN_IDX_W-1:0] cfg_pin;
   logic [1:0]           unused_lsb;

   assign a_int      = int'(bus_addr);
   assign own_hit    = (a_int >= OWN_OFS) && (a_int < OWN_OFS + 4 * NWORDS);
   assign en_hit     = (a_int >= EN_OFS)  && (a_int < EN_OFS + 4 * NWORDS);
   assign route_hit  = (bus_addr[ADDR_W-1:2] == (ADDR_W-2)'(ROUTE_OFS >> 2));
   assign cfg_hit    = (a_int >= CFG_OFS) && (a_int < MAP_END);
   assign own_idx    = IDX_W'((a_int - OWN_OFS) >> 2);
   assign en_idx     = IDX_W'((a_int - EN_OFS) >> 2);
   assign cfg_pin    = PIN_IDX_W'((a_int - CFG_OFS) >> 3);
   assign cfg_second = bus_addr[2];
   assign unused_lsb = bus_addr[1:0];

   // bitmap registers
   logic [DATA_W-1:0]   own_rd, en_rd;
   logic [NUM_PINS-1:0] own_bits;
   logic                unused_own;

   gpio_bitmap_bank #(.NUM_BITS(NUM_PINS), .DATA_W(DATA_W), .RESET_ONES(1'b1)) u_own (
      .clk(clk), .rst_n(rst_n), .hit(own_hit), .we(bus_we), .idx(own_idx),
      .wdata(bus_wdata), .rd_word(own_rd), .bits(own_bits));

   gpio_bitmap_bank #(.NUM_BITS(NUM_PINS), .DATA_W(DATA_W), .RESET_ONES(1'b0)) u_en (
      .clk(clk), .rst_n(rst_n), .hit(en_hit), .we(bus_we), .idx(en_idx),
      .wdata(bus_wdata), .rd_word(en_rd), .bits(irq_en));

   assign unused_own = ^own_bits;

   // routing word
   always_ff @(posedge clk) begin
      if (!rst_n)                  irq_route <= '0;
      else if (route_hit && bus_we) irq_route <= bus_wdata;
   end

   // per-pin configuration
   logic [DATA_W-1:0] pin_rd_a [NUM_PINS];
   logic [DATA_W-1:0] pin_rd_b [NUM_PINS];

   for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
      logic sel;
      assign sel = bus_we && cfg_hit && (cfg_pin == PIN_IDX_W'(p));

      gpio_pin_cfg #(.DATA_W(DATA_W), .SYNC_STAGES(2)) u_pin (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_a    (sel && !cfg_second),
         .wr_b    (sel && cfg_second),
         .wdata   (bus_wdata),
         .pad_in  (pad_in[p]),
         .rd_a    (pin_rd_a[p]),
         .rd_b    (pin_rd_b[p]),
         .pad_oe  (pad_oe[p]),
         .pad_out (pad_out[p]),
         .sense   (sense_val[p]),
         .tmode   (trig_mode[p]),
         .tinv    (trig_inv[p]),
         .pull    (pad_pull[PULL_W*p +: PULL_W])
      );
   end

   // read mux
   always_comb begin
      bus_rdata = '0;
      if (own_hit)        bus_rdata = own_rd;
      else if (en_hit)    bus_rdata = en_rd;
      else if (route_hit) bus_rdata = irq_route;
      else if (cfg_hit) begin
         for (int p = 0; p < NUM_PINS; p++) begin
            if (cfg_pin == PIN_IDX_W'(p))
               bus_rdata = cfg_second ? pin_rd_b[p] : pin_rd_a[p];
         end
      end
   end
endmodule

// File: rtl/gpio_bank_regs_chk.sv
module gpio_bank_regs_chk
   import gpio_bank_pkg::*;
#(
   parameter int NUM_PINS = 94,
   parameter int DATA_W   = 32,
   parameter int ADDR_W   = 12
) (
   input logic                clk,
   input logic                rst_n,
   input logic [ADDR_W-1:0]   bus_addr,
   input logic                bus_we,
   input logic [DATA_W-1:0]   bus_rdata,
   input logic [NUM_PINS-1:0] pad_in,
   input logic [NUM_PINS-1:0] pad_oe,
   input logic [NUM_PINS-1:0] sense_val,
   input logic [NUM_PINS-1:0] irq_en
);
   localparam int NWORDS = (NUM_PINS + DATA_W - 1) / DATA_W;
   localparam int TAIL   = NUM_PINS % DATA_W;
   localparam int MAP_END = CFG_OFS + 8 * NUM_PINS;

   int   a;
   logic hole;
   assign a    = int'(bus_addr);
   assign hole = (a >= OWN_OFS + 4 * NWORDS && a < ROUTE_OFS)
              || (a >= ROUTE_OFS + 4 && a < EN_OFS)
              || (a >= EN_OFS + 4 * NWORDS && a < CFG_OFS)
              || (a >= MAP_END);

   // R1
   rst_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (pad_oe == '0));

   // R5
   oe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_we |=> $stable(pad_oe));

   // R10
   en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_we |=> $stable(irq_en));

   // R6
   sync_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((sense_val & ~$past(pad_in, 2)) == '0));

   // R9
   hole_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hole |-> (bus_rdata == '0));

   if (TAIL != 0) begin : g_tail
      // R8
      tail_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (a >> 2 == (OWN_OFS >> 2) + NWORDS - 1 || a >> 2 == (EN_OFS >> 2) + NWORDS - 1)
         |-> ((bus_rdata >> TAIL) == '0));
   end
endmodule

bind gpio_bank_regs gpio_bank_regs_chk #(
   .NUM_PINS(NUM_PINS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
   .bus_rdata(bus_rdata), .pad_in(pad_in), .pad_oe(pad_oe),
   .sense_val(sense_val), .irq_en(irq_en)
);

// File: tb/gpio_bank_regs_tb.sv
`timescale 1ns/1ps
module gpio_bank_regs_tb;
   localparam int N  = 94;
   localparam int DW = 32;
   localparam int AW = 12;

   logic            clk = 1'b0;
   logic            rst_n;
   logic [AW-1:0]   bus_addr;
   logic            bus_we;
   logic [DW-1:0]   bus_wdata;
   logic [DW-1:0]   bus_rdata;
   logic [N-1:0]    pad_in;
   logic [N-1:0]    pad_oe, pad_out, sense_val, trig_mode, trig_inv, irq_en;
   logic [2*N-1:0]  pad_pull;
   logic [DW-1:0]   irq_route;

   int n_checks = 0;
   int n_err    = 0;

   always #2.5 clk = ~clk;

   gpio_bank_regs #(.NUM_PINS(N), .DATA_W(DW), .ADDR_W(AW)) u_dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
      .pad_oe(pad_oe), .pad_out(pad_out), .pad_pull(pad_pull),
      .sense_val(sense_val), .trig_mode(trig_mode), .trig_inv(trig_inv),
      .irq_en(irq_en), .irq_route(irq_route));

   typedef struct packed {
      logic [AW-1:0] addr;
      logic [DW-1:0] wdata;
      logic [DW-1:0] exp;
   } vec_t;

   // write then read back
   localparam vec_t VECS [11] = '{
      '{12'h100, 32'hFFFF_FFFF, 32'h8000_001D},  // pin 0 word one, masked
      '{12'h3EC, 32'hFFFF_FFFF, 32'h0000_0007},  // pin 93 word two
      '{12'h008, 32'hFFFF_FFFF, 32'h3FFF_FFFF},  // ownership tail word
      '{12'h000, 32'h0000_FFFF, 32'h0000_FFFF},  // ownership word 0
      '{12'h094, 32'hA5A5_A5A5, 32'hA5A5_A5A5},  // enable word 1
      '{12'h07C, 32'h1234_5678, 32'h1234_5678},  // routing word
      '{12'h080, 32'hFFFF_FFFF, 32'h0000_0000},  // status window hole
      '{12'h00C, 32'hFFFF_FFFF, 32'h0000_0000},  // hole past ownership
      '{12'h3F0, 32'hFFFF_FFFF, 32'h0000_0000},  // past last pin
      '{12'h278, 32'h0000_0001, 32'h0000_0001},  // pin 47 GPIO output low
      '{12'h098, 32'hFFFF_FFFF, 32'h3FFF_FFFF}   // enable tail word
   };

   task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic bus_write(logic [AW-1:0] a, logic [DW-1:0] d);
      @(negedge clk);
      bus_addr  = a;
      bus_wdata = d;
      bus_we    = 1'b1;
      @(negedge clk);
      bus_we    = 1'b0;
   endtask

   task automatic bus_read(logic [AW-1:0] a, output logic [DW-1:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
   endtask

   initial begin
      #(200000 * 5);
      n_checks++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [DW-1:0] rd;
      rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0; pad_in = '0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      bus_read(12'h128, rd); check("R1 pin5 word one", rd, 32'h0000_0005);
      bus_read(12'h12C, rd); check("R1 pin5 word two", rd, 32'h0000_0004);
      bus_read(12'h000, rd); check("R1 ownership w0", rd, 32'hFFFF_FFFF);
      bus_read(12'h008, rd); check("R1 ownership tail R8", rd, 32'h3FFF_FFFF);
      bus_read(12'h090, rd); check("R1 enable w0", rd, 32'h0);
      bus_read(12'h07C, rd); check("R1 routing", rd, 32'h0);
      check("R1 pad_oe clear", 32'(pad_oe == '0), 32'd1);

      // R2 R3 R4 R8 R9 table
      foreach (VECS[i]) begin
         bus_write(VECS[i].addr, VECS[i].wdata);
         bus_read(VECS[i].addr, rd);
         check($sformatf("R2 R3 R4 R8 R9 table entry %0d", i), rd, VECS[i].exp);
      end

      // R4 pull output for pin 93
      check("R4 pad_pull pin93", 32'(pad_pull[2*93 +: 2]), 32'd3);
      // R10 trigger bits and enables, routing kept after hole writes
      check("R10 trig_mode pin0", 32'(trig_mode[0]), 32'd1);
      check("R10 trig_inv pin0", 32'(trig_inv[0]), 32'd1);
      check("R10 irq_en pin32", 32'(irq_en[32]), 32'd1);
      check("R10 irq_en pin33", 32'(irq_en[33]), 32'd0);
      check("R9 routing unchanged", irq_route, 32'h1234_5678);
      // R11 low address bits ignored
      bus_read(12'h07E, rd); check("R11 unaligned read", rd, 32'h1234_5678);

      // R5 output enable combinations on pin 10 (pin 47 also drives)
      bus_write(12'h150, 32'h8000_0001);
      check("R5 oe gpio output", 32'(pad_oe[10]), 32'd1);
      check("R5 out high", 32'(pad_out[10]), 32'd1);
      check("R5 oe count", 32'($countones(pad_oe)), 32'd2);
      bus_write(12'h150, 32'h8000_0000);
      check("R5 oe native", 32'(pad_oe[10]), 32'd0);
      bus_write(12'h150, 32'h0000_0005);
      check("R5 oe input", 32'(pad_oe[10]), 32'd0);
      bus_write(12'h150, 32'h0000_0001);
      check("R5 oe output low", 32'(pad_oe[10]), 32'd1);
      check("R5 out low", 32'(pad_out[10]), 32'd0);

      // R7 sensing disabled masks the pad
      pad_in[20] = 1'b1;
      repeat (3) @(negedge clk);
      bus_read(12'h1A0, rd); check("R7 level masked", rd, 32'h0000_0005);
      check("R7 sense_val masked", 32'(sense_val[20]), 32'd0);

      // R6 enable sensing, then two-edge delay on a falling pad
      bus_write(12'h1A4, 32'h0);
      bus_read(12'h1A0, rd); check("R6 level visible", rd, 32'h4000_0005);
      check("R6 sense_val high", 32'(sense_val[20]), 32'd1);
      pad_in[20] = 1'b0;
      @(negedge clk);
      check("R6 one edge later still high", 32'(sense_val[20]), 32'd1);
      @(negedge clk);
      check("R6 two edges later low", 32'(sense_val[20]), 32'd0);
      bus_read(12'h1A0, rd); check("R6 level low", rd, 32'h0000_0005);

      finish_run();
   end
endmodule